// File: doc/BRIEF.md
# Prescaled 8-bit Timer Counter

This block is an 8-bit up-counter for general timing work. Each increment comes from one of two sources. The first is an internal tick that fires once every four system clocks, which stands in for an instruction-rate clock. The second is a chosen edge of an external clock input, which is synchronized to the system clock first. A power-of-two prescaler sits between the source and the counter. It divides by 2 up to 256, or it can be bypassed so that every source event advances the count.

Software reaches the block through a small register port: the count, a control register and a status register. When the count wraps from 0xFF to 0x00, the block sets a sticky overflow flag. The interrupt request output is that flag gated by an enable bit. Writing the count reloads it and restarts the prescaler, so a reload always gives a full prescale period before the next increment.

Top module: `tmr8_top`

## Requirements
- R1: After reset the control register (address 1) reads 0x3F, and both the count (address 0) and the status register (address 2) read 0x00. Control bit 0 selects the source (1 = external input), bit 1 selects the edge (1 = falling), bit 2 bypasses the prescaler (1 = bypass), and bits 5:3 hold the rate code. Status bit 0 is the overflow flag and bit 1 is the interrupt enable.
- R2: With the internal source selected, exactly one source event occurs in every 4 system clocks.
- R3: With the external source and edge bit 0, only low-to-high transitions count. A transition applied between edges N and N+1 first shows in the count after rising edge N+3.
- R4: With the external source and edge bit 1, only high-to-low transitions count.
- R5: With bypass set, the counter advances once per source event.
- R6: With bypass clear, rate code k gives one increment per 2^(k+1) source events, for every k from 0 to 7.
- R7: A write to the count loads the written value and clears the prescaler, so 2^(k+1) further events are needed for the next increment.
- R8: The increment that takes the count from 0xFF to 0x00 sets the overflow flag on the same clock edge. The flag then stays set while further events arrive.
- R9: A status write with bit 0 at 0 clears the flag. An overflow in the same cycle leaves the flag set.
- R10: irq_o is high exactly when both the overflow flag and the interrupt enable are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk_i | input | 1 | External count input, asynchronous |
| reg_addr_i | input | 2 | Register select: 0 count, 1 control, 2 status |
| reg_wr_i | input | 1 | Write strobe for the selected register |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register (combinational) |
| irq_o | output | 1 | Timer interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit count, a 3-bit rate code that reaches the full 1:256 ratio, a divide-by-4 internal tick and a two-stage synchronizer. With these values every rate code can be exercised with external pulses in a few thousand cycles. An overflow can be set up from a single reload to 0xFF. The synchronizer latency is short enough that the bench can place a status write on exactly the edge of the wrap, which tests the set-over-clear priority directly.

// File: rtl/tmr8_pkg.sv
// Package: shared types and register addresses for the prescaled timer.
// Assumes an 8-bit register port and a 2-bit register address.
package tmr8_pkg;

    typedef struct packed {
        logic [2:0] rate;       // prescale code, ratio 2^(rate+1)
        logic       pre_bypass; // 1: prescaler skipped
        logic       edge_fall;  // 1: external falling edges count
        logic       src_ext;    // 1: external input is the source
    } tmr8_ctrl_t;

    localparam logic [1:0] ADDR_COUNT  = 2'd0;
    localparam logic [1:0] ADDR_CTRL   = 2'd1;
    localparam logic [1:0] ADDR_STATUS = 2'd2;

    localparam tmr8_ctrl_t CTRL_RESET = '{rate: 3'b111, pre_bypass: 1'b1,
                                          edge_fall: 1'b1, src_ext: 1'b1};

endpackage

// File: rtl/tmr8_src_sel.sv
// Source selection: builds the internal divided tick and the synchronized,
// edge-detected external input, then picks one as a single-cycle event.
// Assumes ext_clk_i is asynchronous and slower than clk / 2.
module tmr8_src_sel #(
    parameter int INST_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk_i,
    input  logic src_ext,
    input  logic edge_fall,
    output logic src_ev
);
    localparam int DIV_W = (INST_DIV > 1) ? $clog2(INST_DIV) : 1;

    logic                 int_tick;
    logic [SYNC_STAGES:0] sync_q;
    logic                 ext_now;
    logic                 ext_prev;
    logic                 ext_ev;

    generate
        if (INST_DIV > 1) begin : g_div
            logic [DIV_W-1:0] phase_q;
            // Free-running phase counter for the internal tick.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    phase_q <= '0;
                else if (phase_q == DIV_W'(INST_DIV - 1))
                    phase_q <= '0;
                else
                    phase_q <= phase_q + 1'b1;
            end
            assign int_tick = (phase_q == DIV_W'(INST_DIV - 1));
        end else begin : g_nodiv
            assign int_tick = 1'b1;
        end
    endgenerate

    // Synchronizer chain plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_q <= '0;
        else
            sync_q <= {sync_q[SYNC_STAGES-1:0], ext_clk_i};
    end

    assign ext_now  = sync_q[SYNC_STAGES-1];
    assign ext_prev = sync_q[SYNC_STAGES];

    // Pick the counting edge of the synchronized input.
    always_comb begin
        if (edge_fall)
            ext_ev = ext_prev & ~ext_now;
        else
            ext_ev = ext_now & ~ext_prev;
    end

    assign src_ev = src_ext ? ext_ev : int_tick;

endmodule

// File: rtl/tmr8_prescaler.sv
// Prescaler: counts source events and emits one increment per 2^(rate+1)
// events, or passes every event through when bypassed.
// Assumes clr has priority over a coincident event.
module tmr8_prescaler #(
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              src_ev,
    input  logic              bypass,
    input  logic [RATE_W-1:0] rate,
    output logic              inc
);
    localparam int PRE_W = 1 << RATE_W;

    logic [PRE_W:0]   ratio;
    logic [PRE_W-1:0] limit;
    logic [PRE_W-1:0] pcnt_q;
    logic             pre_tick;

    // Terminal count for the selected power-of-two ratio.
    always_comb begin
        ratio = (PRE_W + 1)'(1) << (int'(rate) + 1);
        limit = PRE_W'(ratio - 1'b1);
    end

    assign pre_tick = src_ev && (pcnt_q == limit);

    // Prescale counter, wraps at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            pcnt_q <= '0;
        else if (pre_tick)
            pcnt_q <= '0;
        else if (src_ev)
            pcnt_q <= pcnt_q + 1'b1;
    end

    assign inc = bypass ? src_ev : pre_tick;

endmodule

// File: rtl/tmr8_counter.sv
// Counter core: the loadable up-counter, the sticky overflow flag and the
// interrupt enable. Assumes at most one of the two writes per cycle.
module tmr8_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             wr_cnt,
    input  logic             wr_stat,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf_flag,
    output logic             irq_en
);
    logic wrap;

    assign wrap = inc && !wr_cnt && (cnt == {CNT_W{1'b1}});

    // Counter: load wins over increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (wr_cnt)
            cnt <= wdata;
        else if (inc)
            cnt <= cnt + 1'b1;
    end

    // Overflow flag: set by a wrap, which wins over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_flag <= 1'b0;
        else if (wrap)
            ovf_flag <= 1'b1;
        else if (wr_stat)
            ovf_flag <= wdata[0];
    end

    // Interrupt enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_en <= 1'b0;
        else if (wr_stat)
            irq_en <= wdata[1];
    end

endmodule

// File: rtl/tmr8_top.sv
// Top: register decode and read mux around source selection, prescaler and
// counter core. Assumes a single-cycle write strobe and combinational reads.
module tmr8_top
    import tmr8_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int RATE_W      = 3,
    parameter int INST_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clk_i,
    input  logic [1:0]       reg_addr_i,
    input  logic             reg_wr_i,
    input  logic [CNT_W-1:0] reg_wdata_i,
    output logic [CNT_W-1:0] reg_rdata_o,
    output logic             irq_o
);
    localparam int CTRL_W = $bits(tmr8_ctrl_t);

    tmr8_ctrl_t       ctrl_q;
    logic             wr_cnt;
    logic             wr_ctrl;
    logic             wr_stat;
    logic             src_ev;
    logic             inc;
    logic [CNT_W-1:0] cnt;
    logic             ovf_flag;
    logic             irq_en;

    // Write decode.
    always_comb begin
        wr_cnt  = reg_wr_i && (reg_addr_i == ADDR_COUNT);
        wr_ctrl = reg_wr_i && (reg_addr_i == ADDR_CTRL);
        wr_stat = reg_wr_i && (reg_addr_i == ADDR_STATUS);
    end

    // Control register, all bits set at reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= CTRL_RESET;
        else if (wr_ctrl)
            ctrl_q <= tmr8_ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
    end

    tmr8_src_sel #(
        .INST_DIV    (INST_DIV),
        .SYNC_STAGES (SYNC_STAGES)
    ) src_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_clk_i (ext_clk_i),
        .src_ext   (ctrl_q.src_ext),
        .edge_fall (ctrl_q.edge_fall),
        .src_ev    (src_ev)
    );

    tmr8_prescaler #(
        .RATE_W (RATE_W)
    ) pre_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (wr_cnt),
        .src_ev (src_ev),
        .bypass (ctrl_q.pre_bypass),
        .rate   (ctrl_q.rate),
        .inc    (inc)
    );

    tmr8_counter #(
        .CNT_W (CNT_W)
    ) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (inc),
        .wr_cnt   (wr_cnt),
        .wr_stat  (wr_stat),
        .wdata    (reg_wdata_i),
        .cnt      (cnt),
        .ovf_flag (ovf_flag),
        .irq_en   (irq_en)
    );

    // Read mux.
    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            ADDR_COUNT:  reg_rdata_o = cnt;
            ADDR_CTRL:   reg_rdata_o[CTRL_W-1:0] = ctrl_q;
            ADDR_STATUS: reg_rdata_o[1:0] = {irq_en, ovf_flag};
            default:     reg_rdata_o = '0;
        endcase
    end

    assign irq_o = ovf_flag & irq_en;

endmodule

// File: rtl/tmr8_checker.sv
// Checker: timing properties of the timer, bound into tmr8_top.
module tmr8_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_cnt,
    input logic             wr_ctrl,
    input logic             wr_stat,
    input logic [CNT_W-1:0] wdata,
    input logic             inc,
    input logic             src_ev,
    input logic             bypass,
    input logic [CNT_W-1:0] cnt,
    input logic             flag,
    input logic             en,
    input logic             irq
);
    // R7
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> cnt == $past(wdata));

    // R8
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr_cnt && cnt == {CNT_W{1'b1}}) |=> (flag && cnt == '0));

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !wr_stat) |=> flag);

    // R5
    bypass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && !src_ev && !wr_cnt) |=> $stable(cnt));

    // R6
    inc_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> src_ev);

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && en));

    // R1
    one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_cnt, wr_ctrl, wr_stat}));

endmodule

bind tmr8_top tmr8_checker #(.CNT_W(CNT_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_cnt  (wr_cnt),
    .wr_ctrl (wr_ctrl),
    .wr_stat (wr_stat),
    .wdata   (reg_wdata_i),
    .inc     (inc),
    .src_ev  (src_ev),
    .bypass  (ctrl_q.pre_bypass),
    .cnt     (cnt),
    .flag    (ovf_flag),
    .en      (irq_en),
    .irq     (irq_o)
);

// File: tb/tmr8_top_tb_top.sv
// Scoreboard bench: driver tasks queue expected values, the monitor samples
// the ports 2 ns after each falling edge and compares.
module tmr8_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        string      tag;
        int         sel;   // 0..2 register, 3 irq pin
        logic [7:0] exp;
    } item_t;

    item_t sb_q[$];

    always #10 clk = ~clk;

    tmr8_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_clk_i   (ext),
        .reg_addr_i  (addr),
        .reg_wr_i    (wr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    // Monitor: pop and compare queued expectations.
    always begin
        @(negedge clk);
        #2;
        while (sb_q.size() > 0) begin
            automatic item_t it = sb_q.pop_front();
            automatic logic [7:0] act = (it.sel == 3) ? {7'd0, irq} : rdata;
            checks++;
            if (act !== it.exp)
                begin
                    fails++;
                    $display("FAIL %s sel=%0d actual=%0h expected=%0h",
                             it.tag, it.sel, act, it.exp);
                end
        end
    end

    task automatic expect_val(input string tag, input int sel, input logic [7:0] exp);
        @(negedge clk);
        if (sel < 3) addr = 2'(sel);
        sb_q.push_back('{tag: tag, sel: sel, exp: exp});
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext = 1'b1;
            repeat (3) @(negedge clk);
            ext = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    // Count delta over a window of whole clocks.
    task automatic window(input string tag, input int cycles, input int delta);
        logic [7:0] v0;
        @(negedge clk);
        addr = 2'd0;
        #1 v0 = rdata;
        repeat (cycles - 1) @(negedge clk);
        expect_val(tag, 0, v0 + 8'(delta));
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_val("R1 ctrl", 1, 8'h3F);
        expect_val("R1 count", 0, 8'h00);
        expect_val("R1 status", 2, 8'h00);
        expect_val("R1 irq", 3, 8'h00);

        // R4 default: external falling edges
        @(negedge clk); ext = 1'b1;
        repeat (4) @(negedge clk);
        expect_val("R4 rise ignored", 0, 8'h00);
        ext = 1'b0;
        repeat (4) @(negedge clk);
        expect_val("R4 fall counts", 0, 8'h01);

        // R3 rising edge and latency
        reg_write(2'd1, 8'h05);
        reg_write(2'd0, 8'h00);
        @(negedge clk); ext = 1'b1;
        @(negedge clk);
        expect_val("R3 latency not yet", 0, 8'h00);
        expect_val("R3 latency edge", 0, 8'h01);
        ext = 1'b0;
        repeat (4) @(negedge clk);
        expect_val("R3 fall ignored", 0, 8'h01);

        // R5 bypass
        reg_write(2'd0, 8'h00);
        pulse(5);
        expect_val("R5 bypass five", 0, 8'h05);

        // R6 every rate code
        for (int k = 0; k < 8; k++) begin
            reg_write(2'd1, 8'((k << 3) | 1));
            reg_write(2'd0, 8'h00);
            pulse((1 << (k + 1)) - 1);
            expect_val($sformatf("R6 code %0d short", k), 0, 8'h00);
            pulse(1);
            expect_val($sformatf("R6 code %0d full", k), 0, 8'h01);
        end

        // R7 reload clears prescaler (1:4)
        reg_write(2'd1, 8'h09);
        reg_write(2'd0, 8'h00);
        pulse(3);
        reg_write(2'd0, 8'h10);
        pulse(3);
        expect_val("R7 no early inc", 0, 8'h10);
        pulse(1);
        expect_val("R7 full period", 0, 8'h11);

        // R2 internal source
        reg_write(2'd1, 8'h04);
        window("R2 internal bypass", 80, 20);
        reg_write(2'd1, 8'h08);
        window("R2 internal 1:4", 160, 10);

        // R8 overflow, R10 irq
        reg_write(2'd1, 8'h05);
        reg_write(2'd2, 8'h02);
        reg_write(2'd0, 8'hFF);
        pulse(1);
        expect_val("R8 wrap count", 0, 8'h00);
        expect_val("R8 flag set", 2, 8'h03);
        expect_val("R10 irq high", 3, 8'h01);
        pulse(1);
        expect_val("R8 sticky", 2, 8'h03);
        reg_write(2'd2, 8'h02);
        expect_val("R9 cleared", 2, 8'h02);
        expect_val("R10 irq low", 3, 8'h00);
        reg_write(2'd2, 8'h00);
        reg_write(2'd0, 8'hFF);
        pulse(1);
        expect_val("R10 flag no enable", 2, 8'h01);
        expect_val("R10 irq gated", 3, 8'h00);

        // R9 overflow wins over clear in the same cycle
        reg_write(2'd2, 8'h00);
        reg_write(2'd0, 8'hFF);
        @(negedge clk); ext = 1'b1;
        @(negedge clk);
        @(negedge clk); addr = 2'd2; wdata = 8'h00; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        expect_val("R9 set wins", 2, 8'h01);
        expect_val("R9 wrapped", 0, 8'h00);
        @(negedge clk); ext = 1'b0;

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule